// File: doc/BRIEF.md
# Ring Buffer Feed DMA Channel

This block is a single-channel engine that streams words from a circular buffer in memory into one peripheral data register. Each pulse on the request input starts a short burst, the minor loop. In each beat of the burst the block reads one 32-bit word from the source ring and writes that word to a fixed destination address. After a set number of minor loops, one major loop is complete. The block then pulses an interrupt, moves a byte-position counter forward and keeps serving requests. Software does not need to re-arm it.

The source address moves up by one word per beat. Only its low `MOD_BITS` bits change, so the address wraps inside a buffer of 2^`MOD_BITS` bytes that is aligned to its own size. The bits above that window never change. A pulse on the configuration load input sets the start address and the destination, and restarts the channel. Reads and writes each use a valid/ready handshake, and nothing advances until a beat is accepted.

Top module: `ring_dma_channel`

## Requirements
- R1: Each serviced request produces exactly `BEATS` accepted reads and `BEATS` accepted writes, alternating read then write. The block then returns to idle with `rd_valid` and `wr_valid` low.
- R2: Each write carries the word returned by the read accepted just before it. `rd_valid` and `wr_valid` are never high together.
- R3: After each accepted write the source address increases by 4 bytes within its low `MOD_BITS` bits and wraps to zero there. The bits above the window keep the value loaded by configuration.
- R4: `wr_addr` always equals the destination given at the last configuration load.
- R5: A request that arrives while a minor loop is in progress is held and serviced after that loop ends. Several such requests merge into one.
- R6: `irq` is high for exactly one cycle: the cycle after the last write of every `MINORS`-th minor loop is accepted. The counters then reload and later requests are still served.
- R7: On each `irq`, `ring_pos` advances by `BEATS*4*MINORS` bytes modulo 2^`MOD_BITS`.
- R8: While `rd_valid` or `wr_valid` is high without ready, the address and data on that port hold, and no counter advances.
- R9: A `cfg_load` pulse aborts any activity. It loads the source and destination, clears the held request and both loop counters, and sets `ring_pos` to 0.
- R10: After reset, `rd_valid`, `wr_valid` and `irq` are 0 and `ring_pos` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Load configuration and restart the channel |
| cfg_src_addr | input | ADDR_W | Start address inside the source ring (word aligned) |
| cfg_dst_addr | input | ADDR_W | Fixed peripheral data register address |
| req | input | 1 | Service request, one minor loop per request |
| rd_valid | output | 1 | Memory read request valid |
| rd_ready | input | 1 | Memory accepts the read; `rd_data` is valid in that cycle |
| rd_addr | output | ADDR_W | Memory read address |
| rd_data | input | DATA_W | Memory read data |
| wr_valid | output | 1 | Peripheral write valid |
| wr_ready | input | 1 | Peripheral accepts the write |
| wr_addr | output | ADDR_W | Peripheral write address |
| wr_data | output | DATA_W | Peripheral write data |
| irq | output | 1 | One-cycle major loop completion pulse |
| ring_pos | output | MOD_BITS | Consumer byte position in the ring |

## Verification
The assertions check the local rules on every cycle. These are the handshake hold rule, the read and write ports never being valid together, writes following reads, the fixed destination and the fixed upper source bits, the single-cycle interrupt and the position step. Only the bench's cycle-accurate model can show the rules that need counting: the beat count per request, the exact wrap point, merging of held requests, when the interrupt falls, and a restart by reload in the middle of a run. It shows these across random stalls, back-to-back requests and a start address just below the ring boundary.

// File: rtl/ring_dma_pkg.sv
package ring_dma_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FETCH = 2'd1,
      ST_STORE = 2'd2
   } dma_state_e;
endpackage

// File: rtl/ring_dma_addr.sv
// Source address register with a power-of-two wrap window.
module ring_dma_addr #(
   parameter int ADDR_W   = 32,
   parameter int MOD_BITS = 17,
   parameter int STEP     = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_addr,
   input  logic              step,
   output logic [ADDR_W-1:0] addr
);
   logic [ADDR_W-1:0] addr_q;
   logic [ADDR_W-1:0] addr_nxt;

   generate
      if (MOD_BITS >= ADDR_W) begin : g_flat
         assign addr_nxt = addr_q + ADDR_W'(STEP);
      end else begin : g_wrap
         logic [MOD_BITS-1:0] low_nxt;
         assign low_nxt  = addr_q[MOD_BITS-1:0] + MOD_BITS'(STEP);
         assign addr_nxt = {addr_q[ADDR_W-1:MOD_BITS], low_nxt};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)
         addr_q <= '0;
      else if (load)
         addr_q <= load_addr;
      else if (step)
         addr_q <= addr_nxt;
   end

   assign addr = addr_q;
endmodule

// File: rtl/ring_dma_loops.sv
// Nested beat (minor) and minor-loop (major) counters with auto reload.
module ring_dma_loops #(
   parameter int BEATS  = 16,
   parameter int MINORS = 512
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic beat_done,
   output logic minor_done,
   output logic major_done
);
   localparam int BW = (BEATS  > 1) ? $clog2(BEATS)  : 1;
   localparam int MW = (MINORS > 1) ? $clog2(MINORS) : 1;

   logic [BW-1:0] beat_q;
   logic [MW-1:0] minor_q;
   logic          beat_last;
   logic          minor_last;

   assign beat_last  = (beat_q  == BW'(BEATS - 1));
   assign minor_last = (minor_q == MW'(MINORS - 1));
   assign minor_done = beat_done && beat_last;
   assign major_done = minor_done && minor_last;

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         beat_q  <= '0;
         minor_q <= '0;
      end else if (beat_done) begin
         beat_q <= beat_last ? '0 : beat_q + 1'b1;
         if (beat_last)
            minor_q <= minor_last ? '0 : minor_q + 1'b1;
      end
   end
endmodule

// File: rtl/ring_dma_channel.sv
module ring_dma_channel
   import ring_dma_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int DATA_W   = 32,
   parameter int BEATS    = 16,
   parameter int MINORS   = 512,
   parameter int MOD_BITS = 17
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_load,
   input  logic [ADDR_W-1:0]   cfg_src_addr,
   input  logic [ADDR_W-1:0]   cfg_dst_addr,
   input  logic                req,
   output logic                rd_valid,
   input  logic                rd_ready,
   output logic [ADDR_W-1:0]   rd_addr,
   input  logic [DATA_W-1:0]   rd_data,
   output logic                wr_valid,
   input  logic                wr_ready,
   output logic [ADDR_W-1:0]   wr_addr,
   output logic [DATA_W-1:0]   wr_data,
   output logic                irq,
   output logic [MOD_BITS-1:0] ring_pos
);
   localparam int BYTES_PER_BEAT = DATA_W / 8;
   localparam int MAJOR_BYTES    = BEATS * BYTES_PER_BEAT * MINORS;
   localparam logic [MOD_BITS-1:0] POS_INC = MOD_BITS'(MAJOR_BYTES);

   generate
      if (DATA_W % 8 != 0 || DATA_W < 8) begin : g_bad_data
         $error("DATA_W must be a whole number of bytes");
      end
      if (BEATS < 1 || MINORS < 1) begin : g_bad_loops
         $error("BEATS and MINORS must be at least 1");
      end
      if (MOD_BITS < 2 || MOD_BITS > ADDR_W) begin : g_bad_mod
         $error("MOD_BITS must lie between 2 and ADDR_W");
      end
   endgenerate

   dma_state_e          state_q, state_d;
   logic                pend_q;
   logic [DATA_W-1:0]   data_q;
   logic [ADDR_W-1:0]   dst_q;
   logic                irq_q;
   logic [MOD_BITS-1:0] pos_q;
   logic                rd_fire, wr_fire;
   logic                minor_done, major_done;
   logic [ADDR_W-1:0]   src_addr;

   assign rd_fire = (state_q == ST_FETCH) && rd_ready;
   assign wr_fire = (state_q == ST_STORE) && wr_ready;

   ring_dma_addr #(
      .ADDR_W  (ADDR_W),
      .MOD_BITS(MOD_BITS),
      .STEP    (BYTES_PER_BEAT)
   ) u_addr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (cfg_load),
      .load_addr(cfg_src_addr),
      .step     (wr_fire),
      .addr     (src_addr)
   );

   ring_dma_loops #(
      .BEATS (BEATS),
      .MINORS(MINORS)
   ) u_loops (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (cfg_load),
      .beat_done (wr_fire),
      .minor_done(minor_done),
      .major_done(major_done)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:  if (req || pend_q) state_d = ST_FETCH;
         ST_FETCH: if (rd_ready)      state_d = ST_STORE;
         ST_STORE: if (wr_ready)      state_d = minor_done ? ST_IDLE : ST_FETCH;
         default:                     state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         pend_q  <= 1'b0;
         data_q  <= '0;
         dst_q   <= '0;
         irq_q   <= 1'b0;
         pos_q   <= '0;
      end else if (cfg_load) begin
         state_q <= ST_IDLE;
         pend_q  <= 1'b0;
         dst_q   <= cfg_dst_addr;
         irq_q   <= 1'b0;
         pos_q   <= '0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_IDLE)
            pend_q <= 1'b0;
         else if (req)
            pend_q <= 1'b1;
         if (rd_fire)
            data_q <= rd_data;
         irq_q <= major_done;
         if (major_done)
            pos_q <= pos_q + POS_INC;
      end
   end

   assign rd_valid = (state_q == ST_FETCH);
   assign rd_addr  = src_addr;
   assign wr_valid = (state_q == ST_STORE);
   assign wr_addr  = dst_q;
   assign wr_data  = data_q;
   assign irq      = irq_q;
   assign ring_pos = pos_q;
endmodule

// File: rtl/ring_dma_channel_chk.sv
module ring_dma_channel_chk #(
   parameter int ADDR_W   = 32,
   parameter int DATA_W   = 32,
   parameter int BEATS    = 16,
   parameter int MINORS   = 512,
   parameter int MOD_BITS = 17
) (
   input logic                clk,
   input logic                rst_n,
   input logic                cfg_load,
   input logic [ADDR_W-1:0]   cfg_src_addr,
   input logic [ADDR_W-1:0]   cfg_dst_addr,
   input logic                rd_valid,
   input logic                rd_ready,
   input logic [ADDR_W-1:0]   rd_addr,
   input logic                wr_valid,
   input logic                wr_ready,
   input logic [ADDR_W-1:0]   wr_addr,
   input logic [DATA_W-1:0]   wr_data,
   input logic                irq,
   input logic [MOD_BITS-1:0] ring_pos
);
   localparam logic [MOD_BITS-1:0] POS_INC = MOD_BITS'(BEATS * (DATA_W / 8) * MINORS);

   logic [ADDR_W-1:0] dst_shadow;
   logic [ADDR_W-1:0] src_shadow;
   logic              cfg_seen;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dst_shadow <= '0;
         src_shadow <= '0;
         cfg_seen   <= 1'b0;
      end else if (cfg_load) begin
         dst_shadow <= cfg_dst_addr;
         src_shadow <= cfg_src_addr;
         cfg_seen   <= 1'b1;
      end
   end

   assert_rd_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && !rd_ready && !cfg_load) |=> (rd_valid && $stable(rd_addr)));

   assert_wr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && !wr_ready && !cfg_load) |=> (wr_valid && $stable(wr_data)));

   assert_one_port_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_valid && wr_valid));

   assert_write_after_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && rd_ready && !cfg_load) |=> wr_valid);

   assert_fixed_dst_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && cfg_seen) |-> (wr_addr == dst_shadow));

   assert_upper_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && cfg_seen) |->
         ((rd_addr >> MOD_BITS) == (src_shadow >> MOD_BITS)));

   assert_irq_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);

   assert_pos_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !$past(cfg_load)) |-> (ring_pos == $past(ring_pos) + POS_INC));
endmodule

bind ring_dma_channel ring_dma_channel_chk #(
   .ADDR_W  (ADDR_W),
   .DATA_W  (DATA_W),
   .BEATS   (BEATS),
   .MINORS  (MINORS),
   .MOD_BITS(MOD_BITS)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_load    (cfg_load),
   .cfg_src_addr(cfg_src_addr),
   .cfg_dst_addr(cfg_dst_addr),
   .rd_valid    (rd_valid),
   .rd_ready    (rd_ready),
   .rd_addr     (rd_addr),
   .wr_valid    (wr_valid),
   .wr_ready    (wr_ready),
   .wr_addr     (wr_addr),
   .wr_data     (wr_data),
   .irq         (irq),
   .ring_pos    (ring_pos)
);

// File: tb/ring_dma_channel_test.sv
module ring_dma_channel_test;
   localparam int AW = 32;
   localparam int DW = 32;
   localparam int NB = 4;
   localparam int NM = 3;
   localparam int MB = 6;
   localparam int RING = 1 << MB;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_load = 1'b0;
   logic [AW-1:0] cfg_src_addr = '0;
   logic [AW-1:0] cfg_dst_addr = '0;
   logic          req = 1'b0;
   logic          rd_valid, wr_valid, irq;
   logic          rd_ready = 1'b0;
   logic          wr_ready = 1'b0;
   logic [AW-1:0] rd_addr, wr_addr;
   logic [DW-1:0] rd_data, wr_data;
   logic [MB-1:0] ring_pos;

   int checks = 0;
   int errors = 0;
   int irq_seen = 0;
   bit done = 0;

   always #2 clk = ~clk;

   function automatic logic [DW-1:0] memf(input logic [AW-1:0] a);
      return (a * 32'h0001_9E37) ^ 32'hC0DE_0000;
   endfunction

   assign rd_data = memf(rd_addr);

   ring_dma_channel #(
      .ADDR_W(AW), .DATA_W(DW), .BEATS(NB), .MINORS(NM), .MOD_BITS(MB)
   ) uut (
      .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load),
      .cfg_src_addr(cfg_src_addr), .cfg_dst_addr(cfg_dst_addr),
      .req(req), .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
      .rd_data(rd_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
      .wr_addr(wr_addr), .wr_data(wr_data), .irq(irq), .ring_pos(ring_pos)
   );

   // Behavioural reference: 0 idle, 1 reading, 2 writing
   int            m_st = 0;
   logic [AW-1:0] m_src = '0;
   logic [AW-1:0] m_dst = '0;
   logic [DW-1:0] m_data = '0;
   int            m_beat = 0;
   int            m_minor = 0;
   bit            m_pend = 0;
   bit            m_irq = 0;
   int            m_pos = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_st = 0; m_src = '0; m_dst = '0; m_data = '0;
         m_beat = 0; m_minor = 0; m_pend = 0; m_irq = 0; m_pos = 0;
      end else if (cfg_load) begin
         m_st = 0; m_src = cfg_src_addr; m_dst = cfg_dst_addr;
         m_beat = 0; m_minor = 0; m_pend = 0; m_irq = 0; m_pos = 0;
      end else begin
         m_irq = 0;
         if (m_st == 0) begin
            if (req || m_pend) m_st = 1;
            m_pend = 0;
         end else if (m_st == 1) begin
            if (req) m_pend = 1;
            if (rd_ready) begin
               m_data = memf(m_src);
               m_st = 2;
            end
         end else begin
            if (req) m_pend = 1;
            if (wr_ready) begin
               m_src = (m_src & ~AW'(RING - 1)) | ((m_src + 4) & AW'(RING - 1));
               m_beat++;
               m_st = 1;
               if (m_beat == NB) begin
                  m_beat = 0;
                  m_st = 0;
                  m_minor++;
                  if (m_minor == NM) begin
                     m_minor = 0;
                     m_irq = 1;
                     m_pos = (m_pos + NB * 4 * NM) % RING;
                  end
               end
            end
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      chk(rd_valid == (m_st == 1), "R1", "rd_valid", 64'(rd_valid), 64'(m_st == 1));
      chk(wr_valid == (m_st == 2), "R5", "wr_valid", 64'(wr_valid), 64'(m_st == 2));
      if (rd_valid)
         chk(rd_addr == m_src, "R3", "rd_addr", 64'(rd_addr), 64'(m_src));
      if (wr_valid) begin
         chk(wr_data == m_data, "R2", "wr_data", 64'(wr_data), 64'(m_data));
         chk(wr_addr == m_dst, "R4", "wr_addr", 64'(wr_addr), 64'(m_dst));
      end
      chk(irq == m_irq, "R6", "irq", 64'(irq), 64'(m_irq));
      chk(int'(ring_pos) == m_pos, "R7", "ring_pos", 64'(ring_pos), 64'(m_pos));
      if (irq) irq_seen++;
   endtask

   task automatic cyc();
      @(negedge clk);
      compare_all();
   endtask

   task automatic load(input logic [AW-1:0] s, input logic [AW-1:0] d);
      cfg_src_addr = s; cfg_dst_addr = d; cfg_load = 1'b1;
      cyc();
      cfg_load = 1'b0;
   endtask

   // rate: a request each cycle with probability 1/rate; stall: percent not ready
   task automatic run(input int n, input int rate, input int stall);
      for (int i = 0; i < n; i++) begin
         req      = ($urandom % rate) == 0;
         rd_ready = ($urandom % 100) >= stall;
         wr_ready = ($urandom % 100) >= stall;
         cyc();
      end
      req = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd7));
      // R10 reset state
      repeat (3) cyc();
      chk(!rd_valid && !wr_valid && !irq && ring_pos == 0, "R10", "reset outputs",
          {rd_valid, wr_valid, irq, 61'(ring_pos)}, 64'd0);
      rst_n = 1'b1;
      cyc();
      // R9: configure, start three words below the ring boundary to exercise R3 wrap
      load(32'h0000_8034, 32'h4000_0020);
      run(1500, 8, 25);
      run(40, 1, 0);          // R5: back-to-back requests merge
      run(200, 1, 0);
      // R8: long stalls with requests pending
      run(60, 2, 90);
      run(200, 30, 0);
      // R9: reload in the middle of traffic
      run(7, 1, 0);
      load(32'h1234_567C, 32'h5000_0104);
      chk(!rd_valid && !wr_valid && ring_pos == 0, "R9", "after reload",
          {rd_valid, wr_valid, 62'(ring_pos)}, 64'd0);
      run(2000, 5, 40);
      run(300, 40, 0);
      // R1: idle once requests stop
      chk(!rd_valid && !wr_valid, "R1", "idle after drain",
          {62'd0, rd_valid, wr_valid}, 64'd0);
      chk(irq_seen >= 4, "R6", "completion count", 64'(irq_seen), 64'd4);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule